// File: doc/BRIEF.md
# Display Controller Interrupt Aggregator

This unit gathers the one-cycle event pulses raised by a display controller's timing and DMA logic and turns them into a single level interrupt request. Every pulse lands in a sticky raw status register. A separate enable register decides which pending events may drive the request line. Software can read both the raw view and the enabled (masked) view. It acknowledges events by writing ones to either status view. It changes enables through a dedicated set address and a dedicated clear address, so it never needs a read-modify-write. After servicing, it writes the end-of-service address, which forces a short low gap on the request line before the line may rise again.

The unit also has a recovery flag. This flag is high while both the sync-lost event and the FIFO-underflow event are pending. Software treats that combination as the signal to stop the raster engine, clear status and restart it.

Top module: `lcd_irq_unit`

## Requirements
- R1: After reset, raw status, masked status and enables all read 0, and `irq_o` and `recovery_pending` are low.
- R2: An event pulse sets its raw status bit on the next clock edge, at these positions: frame done bit 0, sync lost bit 2, FIFO underflow bit 5, palette load done bit 6, end of frame 0 bit 8, end of frame 1 bit 9. All other status and enable bits always read 0, so the implemented mask is 0x365.
- R3: Writing to the raw status address (0) or the masked status address (1) clears exactly the status bits written as 1. Writing all ones clears every pending event.
- R4: If an event pulse arrives in the same cycle as a write that clears its bit, the bit stays set. Other bits in that write are still cleared.
- R5: Writing to the enable-set address (2) sets the enable bits written as 1 and leaves the rest unchanged. Reads at address 2 and at address 3 both return the enable register.
- R6: Writing to the enable-clear address (3) clears the enable bits written as 1 and leaves the rest unchanged.
- R7: The masked status read (address 1) equals raw status AND enables.
- R8: `irq_o` rises one cycle after a masked bit becomes nonzero. It falls one cycle after the masked status becomes zero.
- R9: A write of any value to the end-of-service address (4) holds `irq_o` low for the two cycles after that write. In the cycle after those two, `irq_o` rises again if masked events are still pending.
- R10: `recovery_pending` is high exactly when the raw sync-lost bit and the raw FIFO-underflow bit are both set.
- R11: Raw status records events whatever the enables are. With no enable set, `irq_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_frame_done | input | 1 | Frame-done pulse |
| evt_sync_lost | input | 1 | Sync-lost pulse |
| evt_underflow | input | 1 | FIFO-underflow pulse |
| evt_pal_done | input | 1 | Palette-load-done pulse |
| evt_eof0 | input | 1 | End-of-frame-0 pulse |
| evt_eof1 | input | 1 | End-of-frame-1 pulse |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| irq_o | output | 1 | Level interrupt request |
| recovery_pending | output | 1 | Sync lost and underflow both pending |

## Verification
The bench fires each event on its own to pin down its bit position. It then fires several events together and clears them with partial and all-ones masks, which separates clearing only the written bits from clearing everything. It sets and clears enables in steps so that a stuck or overwritten enable bit shows up, and it compares masked and raw reads under mixed enables. The timing checks measure the exact cycle in which the request line rises and falls: after an event, after an acknowledge, after an end-of-service write while events are still pending, and when an event collides with a clear of the same bit.

// File: rtl/lcd_irq_pkg.sv
package lcd_irq_pkg;
  localparam int STAT_W  = 10;
  localparam int NUM_EVT = 6;

  // event vector order used inside the unit
  localparam int EV_FRAME_DONE = 0;
  localparam int EV_SYNC_LOST  = 1;
  localparam int EV_UNDERFLOW  = 2;
  localparam int EV_PAL_DONE   = 3;
  localparam int EV_EOF0       = 4;
  localparam int EV_EOF1       = 5;

  typedef enum logic [2:0] {
    SEL_RAW    = 3'd0,
    SEL_MASKED = 3'd1,
    SEL_EN_SET = 3'd2,
    SEL_EN_CLR = 3'd3,
    SEL_EOI    = 3'd4
  } reg_sel_e;

  // status bit position of each event index
  function automatic int evt_pos(input int idx);
    case (idx)
      EV_FRAME_DONE: return 0;
      EV_SYNC_LOST:  return 2;
      EV_UNDERFLOW:  return 5;
      EV_PAL_DONE:   return 6;
      EV_EOF0:       return 8;
      default:       return 9;
    endcase
  endfunction

  function automatic logic [STAT_W-1:0] impl_bits();
    logic [STAT_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_EVT; i++) m[evt_pos(i)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank
  import lcd_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EVT-1:0] evt_pulse,
  input  logic              clr_we,
  input  logic [DATA_W-1:0] clr_mask,
  output logic [DATA_W-1:0] raw_o
);
  localparam logic [DATA_W-1:0] IMPL = DATA_W'(impl_bits());

  logic [DATA_W-1:0] raw_q;
  logic [DATA_W-1:0] evt_bits;

  // spread event pulses onto their status positions
  always_comb begin
    evt_bits = '0;
    for (int i = 0; i < NUM_EVT; i++) evt_bits[evt_pos(i)] = evt_pulse[i];
  end

  // clear first, then a same-cycle event re-sets the bit
  function automatic logic [DATA_W-1:0] next_raw(
    input logic [DATA_W-1:0] cur,
    input logic [DATA_W-1:0] clr,
    input logic [DATA_W-1:0] setb
  );
    return ((cur & ~clr) | setb) & IMPL;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= next_raw(raw_q, clr_we ? clr_mask : '0, evt_bits);
  end

  assign raw_o = raw_q;

  a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_bits) |=> ((raw_q & $past(evt_bits)) == $past(evt_bits)));
endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank
  import lcd_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [DATA_W-1:0] wmask,
  output logic [DATA_W-1:0] en_o
);
  localparam logic [DATA_W-1:0] IMPL = DATA_W'(impl_bits());

  logic [DATA_W-1:0] en_q;

  function automatic logic [DATA_W-1:0] next_en(
    input logic [DATA_W-1:0] cur,
    input logic              s,
    input logic              c,
    input logic [DATA_W-1:0] m
  );
    logic [DATA_W-1:0] r;
    r = cur;
    if (s) r = r | m;
    if (c) r = r & ~m;
    return r & IMPL;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= next_en(en_q, set_we, clr_we, wmask);
  end

  assign en_o = en_q;

  a_r5_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && !clr_we) |=> ((en_q & $past(wmask & IMPL)) == $past(wmask & IMPL)));

  a_r6_clear_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((en_q & $past(wmask)) == '0));
endmodule

// File: rtl/irq_eoi_gate.sv
module irq_eoi_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic masked_any,
  input  logic eoi_we,
  output logic irq_o
);
  logic irq_q;
  logic gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      gap_q <= 1'b0;
    end else begin
      gap_q <= eoi_we;
      irq_q <= masked_any && !eoi_we && !gap_q;
    end
  end

  assign irq_o = irq_q;

  a_r9_eoi_gap: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_we |=> !irq_o ##1 !irq_o);

  a_r8_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(masked_any));
endmodule

// File: rtl/lcd_irq_unit.sv
module lcd_irq_unit
  import lcd_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_frame_done,
  input  logic              evt_sync_lost,
  input  logic              evt_underflow,
  input  logic              evt_pal_done,
  input  logic              evt_eof0,
  input  logic              evt_eof1,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              recovery_pending
);
  localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'(SEL_RAW);
  localparam logic [ADDR_W-1:0] A_MASKED = ADDR_W'(SEL_MASKED);
  localparam logic [ADDR_W-1:0] A_EN_SET = ADDR_W'(SEL_EN_SET);
  localparam logic [ADDR_W-1:0] A_EN_CLR = ADDR_W'(SEL_EN_CLR);
  localparam logic [ADDR_W-1:0] A_EOI    = ADDR_W'(SEL_EOI);

  logic [NUM_EVT-1:0] evt_vec;
  logic [DATA_W-1:0]  raw_w, en_w, masked_w;
  logic               stat_clr_we, en_set_we, en_clr_we, eoi_we;

  always_comb begin
    evt_vec = '0;
    evt_vec[EV_FRAME_DONE] = evt_frame_done;
    evt_vec[EV_SYNC_LOST]  = evt_sync_lost;
    evt_vec[EV_UNDERFLOW]  = evt_underflow;
    evt_vec[EV_PAL_DONE]   = evt_pal_done;
    evt_vec[EV_EOF0]       = evt_eof0;
    evt_vec[EV_EOF1]       = evt_eof1;
  end

  assign stat_clr_we = bus_we && (bus_addr == A_RAW || bus_addr == A_MASKED);
  assign en_set_we   = bus_we && (bus_addr == A_EN_SET);
  assign en_clr_we   = bus_we && (bus_addr == A_EN_CLR);
  assign eoi_we      = bus_we && (bus_addr == A_EOI);

  irq_status_bank #(.DATA_W(DATA_W)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_pulse (evt_vec),
    .clr_we    (stat_clr_we),
    .clr_mask  (bus_wdata),
    .raw_o     (raw_w)
  );

  irq_enable_bank #(.DATA_W(DATA_W)) u_enable (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_we (en_set_we),
    .clr_we (en_clr_we),
    .wmask  (bus_wdata),
    .en_o   (en_w)
  );

  assign masked_w = raw_w & en_w;

  irq_eoi_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .masked_any (|masked_w),
    .eoi_we     (eoi_we),
    .irq_o      (irq_o)
  );

  always_comb begin
    case (bus_addr)
      A_RAW:              bus_rdata = raw_w;
      A_MASKED:           bus_rdata = masked_w;
      A_EN_SET, A_EN_CLR: bus_rdata = en_w;
      default:            bus_rdata = '0;
    endcase
  end

  assign recovery_pending = raw_w[evt_pos(EV_SYNC_LOST)] && raw_w[evt_pos(EV_UNDERFLOW)];

  a_r10_recovery_source: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_sync_lost && evt_underflow) |=> recovery_pending);
endmodule

// File: tb/lcd_irq_unit_bench.sv
`timescale 1ns/1ps
module lcd_irq_unit_bench;
  localparam int DW = 32;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] ev = '0; // 0 fd,1 sl,2 uf,3 pl,4 e0,5 e1
  logic bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic irq_o, recovery_pending;

  int n_checks = 0;
  int n_fail = 0;

  // bit positions stated by R2
  localparam logic [DW-1:0] B_FD = 32'h001, B_SL = 32'h004, B_UF = 32'h020,
                            B_PL = 32'h040, B_E0 = 32'h100, B_E1 = 32'h200;
  localparam logic [DW-1:0] ALLB = 32'h365;

  always #2.5 clk = ~clk;

  lcd_irq_unit #(.DATA_W(DW), .ADDR_W(AW)) u_lcd_irq_unit (
    .clk(clk), .rst_n(rst_n),
    .evt_frame_done(ev[0]), .evt_sync_lost(ev[1]), .evt_underflow(ev[2]),
    .evt_pal_done(ev[3]), .evt_eof0(ev[4]), .evt_eof1(ev[5]),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .recovery_pending(recovery_pending)
  );

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one clock edge with optional write and optional events
  task automatic cycle(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic [5:0] e);
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d; ev = e;
    @(negedge clk);
    bus_we = 1'b0; ev = '0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    cycle(1'b1, a, d, 6'b0);
  endtask

  task automatic pulse(input logic [5:0] e);
    cycle(1'b0, '0, '0, e);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic clean();
    wr(3'd3, '1);
    wr(3'd0, '1);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    rd(3'd0, v); check("R1 raw", v, 0);
    rd(3'd1, v); check("R1 masked", v, 0);
    rd(3'd2, v); check("R1 enable", v, 0);
    check("R1 irq", irq_o, 0);
    check("R1 recovery", recovery_pending, 0);
  endtask

  task automatic t_positions();
    logic [DW-1:0] v;
    logic [DW-1:0] exp_pos [6];
    exp_pos[0] = B_FD; exp_pos[1] = B_SL; exp_pos[2] = B_UF;
    exp_pos[3] = B_PL; exp_pos[4] = B_E0; exp_pos[5] = B_E1;
    for (int i = 0; i < 6; i++) begin
      pulse(6'(1 << i));
      rd(3'd0, v); check("R2 event position", v, exp_pos[i]);
      wr(3'd0, '1);
    end
    wr(3'd2, '1);
    rd(3'd2, v); check("R2 implemented enables", v, ALLB);
    pulse(6'h3f);
    rd(3'd0, v); check("R2 implemented status", v, ALLB);
    clean();
  endtask

  task automatic t_no_enable();
    logic [DW-1:0] v;
    pulse(6'h3f);
    @(negedge clk); @(negedge clk);
    check("R11 irq without enable", irq_o, 0);
    rd(3'd0, v); check("R11 raw still recorded", v, ALLB);
    clean();
  endtask

  task automatic t_w1c();
    logic [DW-1:0] v;
    pulse(6'b110101); // fd, uf, e0, e1
    wr(3'd0, B_E0 | B_FD);
    rd(3'd0, v); check("R3 partial clear raw addr", v, B_UF | B_E1);
    wr(3'd1, B_UF);
    rd(3'd0, v); check("R3 clear via masked addr", v, B_E1);
    pulse(6'h3f);
    wr(3'd0, '1);
    rd(3'd0, v); check("R3 all ones clear", v, 0);
  endtask

  task automatic t_event_wins();
    logic [DW-1:0] v;
    pulse(6'b110000); // e0, e1
    cycle(1'b1, 3'd0, B_E0 | B_E1, 6'b010000); // clear both, e0 re-fires
    rd(3'd0, v); check("R4 event beats clear", v, B_E0);
    clean();
  endtask

  task automatic t_enables();
    logic [DW-1:0] v;
    wr(3'd2, B_E0 | B_UF);
    wr(3'd2, B_SL);
    rd(3'd2, v); check("R5 set keeps others", v, B_E0 | B_UF | B_SL);
    wr(3'd3, B_E0);
    rd(3'd3, v); check("R6 clear only written", v, B_UF | B_SL);
    wr(3'd3, 0);
    rd(3'd2, v); check("R6 zero clear no effect", v, B_UF | B_SL);
    clean();
  endtask

  task automatic t_masked();
    logic [DW-1:0] v;
    wr(3'd2, B_PL | B_E1 | B_FD);
    pulse(6'b101011); // fd, sl, pl, e1
    rd(3'd1, v); check("R7 masked", v, B_PL | B_E1 | B_FD);
    wr(3'd3, B_E1);
    rd(3'd1, v); check("R7 masked after disable", v, B_PL | B_FD);
    rd(3'd0, v); check("R7 raw unaffected", v, B_FD | B_SL | B_PL | B_E1);
    clean();
  endtask

  task automatic t_irq_timing();
    wr(3'd2, B_E0);
    pulse(6'b010000);
    check("R8 irq not yet", irq_o, 0);
    @(negedge clk);
    check("R8 irq rises", irq_o, 1);
    wr(3'd0, B_E0);
    check("R8 irq one more cycle", irq_o, 1);
    @(negedge clk);
    check("R8 irq falls", irq_o, 0);
    clean();
  endtask

  task automatic t_eoi();
    wr(3'd2, B_PL);
    pulse(6'b001000);
    @(negedge clk);
    check("R9 irq pending before eoi", irq_o, 1);
    wr(3'd4, 32'h0);
    check("R9 gap cycle 1", irq_o, 0);
    @(negedge clk);
    check("R9 gap cycle 2", irq_o, 0);
    @(negedge clk);
    check("R9 re-assert", irq_o, 1);
    wr(3'd0, '1);
    @(negedge clk);
    wr(3'd4, 32'h1234);
    @(negedge clk); @(negedge clk);
    check("R9 eoi with nothing pending", irq_o, 0);
    clean();
  endtask

  task automatic t_recovery();
    pulse(6'b000010);
    check("R10 sync lost alone", recovery_pending, 0);
    pulse(6'b000100);
    check("R10 both pending", recovery_pending, 1);
    wr(3'd0, B_UF);
    check("R10 after clear", recovery_pending, 0);
    clean();
  endtask

  initial begin
    #1ms;
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_positions();
    t_no_enable();
    t_w1c();
    t_event_wins();
    t_enables();
    t_masked();
    t_irq_timing();
    t_eoi();
    t_recovery();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule